// File: doc/BRIEF.md
# Serial Configuration Register File with Delayed Readback

This block is the serial slave in front of the configuration registers of a four-channel output converter. A host shifts 24-bit frames in on a serial data line, most significant bit first, while chip select is held low. The frame takes effect when chip select returns high. The top bit of a frame chooses between a write and a read. The next two bits name a device address, which is compared with address pins strapped on the board. A 5-bit register code and a 16-bit data field follow.

Each channel owns six registers: data, control, gain, offset, clear code and slew rate. Three device-wide registers complete the map: status (read-only, taken from an input), main control and DC-DC control. A read frame does not return data in the same transfer. It latches the selected register, and the host collects that value during the following transfer. That transfer is usually another read or a no-operation frame. The no-operation frame is a write to an unused code, for example 0x3CE000 for device 1.

The serial interface is oversampled by the system clock. The serial clock, chip select and data lines pass through two-stage synchronisers. Incoming bits are captured on rising serial-clock edges, and the return line advances on falling edges.

Top module: `spi_rf_top`

## Requirements
- R1: After reset every register is zero except the four channel gain registers, which hold 0xFFFF, and the return line enable `sdo_oe_o` is low.
- R2: A valid write frame (bit 23 = 0, exactly 24 rising serial-clock edges, bits 22:21 equal to `dev_addr_i`) stores bits 15:0 into the register named by bits 20:16. Codes 0–23 map to `ch_regs_o` slot `code` (16 bits at `code*16`), 25 to `main_ctrl_o` and 26 to `dcdc_ctrl_o`. No other event changes these outputs.
- R3: In the slew-rate registers (codes 20–23), only bit 12 (enable), bits 6:3 (clock-rate code) and bits 2:0 (step code) are stored. Every other bit reads zero.
- R4: A valid read frame (bit 23 = 1) with code C makes the next transfer shift out, MSB first on falling serial-clock edges, the word {1'b0, device address, C, value}. Codes 0–3 select the data registers of channels A–D, 4–7 control, 8–11 gain, 12–15 offset, 16–19 clear code, 20–23 slew rate, 25 main control and 26 DC-DC control.
- R5: Code 24 reads `status_i` as sampled when the read frame completes. A write to code 24 changes nothing.
- R6: Codes 27–31 read as zero, and writes to them change nothing. This includes the no-operation frames 0x1CE000 and 0x3CE000.
- R7: Before any read, and in the transfer after a valid write frame, the return line shifts out all zeros.
- R8: In a frame whose bits 22:21 differ from `dev_addr_i`, `sdo_oe_o` falls once the third bit has been received and stays low for the rest of that frame. No register changes, and the pending readback word is kept.
- R9: A frame with other than exactly 24 rising serial-clock edges is discarded. No register changes, and the pending readback word is kept.
- R10: `sdo_oe_o` rises only when chip select falls. It is high from the start of every transfer and low while chip select is high.
- R11: Bits 15:0 of a read frame have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr_i | input | 2 | Strapped device address |
| sclk_i | input | 1 | Serial clock, idle low |
| cs_n_i | input | 1 | Active-low chip select framing a transfer |
| mosi_i | input | 1 | Serial data from the host |
| status_i | input | 16 | Status flags returned for read code 24 |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Drive enable for `sdo_o`; low means high impedance |
| ch_regs_o | output | 384 | Twenty-four channel registers, slot n at bits n*16+15:n*16 |
| main_ctrl_o | output | 16 | Main control register |
| dcdc_ctrl_o | output | 16 | DC-DC control register |

## Verification
The bench first writes every one of the 32 codes with a distinct value, then reads all 32 back with nonzero filler in the low bits. Comparing each transfer's output with the previous frame's target separates a correct one-frame delay from a same-frame or two-frame delay, and separates correct code decoding from a swapped channel or register kind. Masked slew writes, the status code read while the status input changes, and the reserved codes show whether storage is gated per code. Frames for a foreign address and frames of 23 or 25 bits are placed between a read and its collecting frame. This tells whether the block ignores those frames entirely or lets them clobber the pending word or a register.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int FRAME_W   = 24;
  localparam int REG_W     = 16;
  localparam int CODE_W    = 5;
  localparam int DADDR_W   = 2;
  localparam int RW_POS    = 23;
  localparam int DADDR_LSB = 21;
  localparam int CODE_LSB  = 16;
  localparam int KINDS     = 6;
  localparam int KIND_GAIN = 2;
  localparam int KIND_SLEW = 5;
  localparam logic [REG_W-1:0] SLEW_KEEP = 16'h107F;

  function automatic logic [FRAME_W-1:0] rb_word(
    input logic [DADDR_W-1:0] addr,
    input logic [CODE_W-1:0]  code,
    input logic [REG_W-1:0]   value);
    return {1'b0, addr, code, value};
  endfunction
endpackage

// File: rtl/spi_rf_frame.sv
module spi_rf_frame
  import spi_rf_pkg::*;
#(
  parameter int FW = FRAME_W,
  parameter int AW = DADDR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dev_addr_i,
  input  logic          sclk_i,
  input  logic          cs_n_i,
  input  logic          mosi_i,
  input  logic [FW-1:0] load_word_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          cs_fall_o,
  output logic          frame_valid_o,
  output logic [FW-1:0] frame_o
);
  localparam int CNT_W = $clog2(FW + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FW);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FW + 1);
  localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(AW);

  logic [2:0]       sclk_sy, cs_sy, mosi_sy;
  logic [FW-1:0]    rx_q, tx_q;
  logic [CNT_W-1:0] cnt_q;
  logic             match_q;
  logic             sclk_rise, sclk_fall, cs_rise;
  logic [AW-1:0]    addr_now;

  assign sclk_rise = sclk_sy[1] & ~sclk_sy[2];
  assign sclk_fall = ~sclk_sy[1] & sclk_sy[2];
  assign cs_fall_o = ~cs_sy[1] & cs_sy[2];
  assign cs_rise   = cs_sy[1] & ~cs_sy[2];
  assign addr_now  = {rx_q[AW-2:0], mosi_sy[1]};
  assign sdo_o     = tx_q[FW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sy       <= '0;
      cs_sy         <= '1;
      mosi_sy       <= '0;
      rx_q          <= '0;
      tx_q          <= '0;
      cnt_q         <= '0;
      match_q       <= 1'b0;
      sdo_oe_o      <= 1'b0;
      frame_valid_o <= 1'b0;
      frame_o       <= '0;
    end else begin
      sclk_sy       <= {sclk_sy[1:0], sclk_i};
      cs_sy         <= {cs_sy[1:0], cs_n_i};
      mosi_sy       <= {mosi_sy[1:0], mosi_i};
      frame_valid_o <= 1'b0;
      if (cs_fall_o) begin
        rx_q     <= '0;
        tx_q     <= load_word_i;
        cnt_q    <= '0;
        match_q  <= 1'b1;
        sdo_oe_o <= 1'b1;
      end else if (cs_rise) begin
        sdo_oe_o      <= 1'b0;
        frame_valid_o <= match_q && (cnt_q == CNT_FULL);
        frame_o       <= rx_q;
      end else if (!cs_sy[1]) begin
        if (sclk_rise) begin
          rx_q <= {rx_q[FW-2:0], mosi_sy[1]};
          if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_ADDR && addr_now != dev_addr_i) begin
            match_q  <= 1'b0;
            sdo_oe_o <= 1'b0;
          end
        end
        if (sclk_fall) tx_q <= {tx_q[FW-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = REG_W,
  parameter int CW  = CODE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en_i,
  input  logic [CW-1:0]         wr_code_i,
  input  logic [DW-1:0]         wr_data_i,
  input  logic [CW-1:0]         rd_code_i,
  input  logic [DW-1:0]         status_i,
  output logic [DW-1:0]         rd_data_o,
  output logic [KINDS*NCH*DW-1:0] ch_regs_o,
  output logic [DW-1:0]         main_ctrl_o,
  output logic [DW-1:0]         dcdc_ctrl_o
);
  localparam int NCR       = KINDS * NCH;
  localparam int CODE_STAT = NCR;
  localparam int CODE_MAIN = NCR + 1;
  localparam int CODE_DCDC = NCR + 2;

  logic [DW-1:0] regs_q [NCR];

  for (genvar i = 0; i < NCR; i++) begin : g_ch
    localparam int KIND = i / NCH;
    localparam logic [DW-1:0] RST_V = (KIND == KIND_GAIN) ? '1 : '0;
    localparam logic [DW-1:0] KEEP  = (KIND == KIND_SLEW) ? DW'(SLEW_KEEP) : '1;
    always_ff @(posedge clk) begin
      if (rst) regs_q[i] <= RST_V;
      else if (wr_en_i && wr_code_i == CW'(i)) regs_q[i] <= wr_data_i & KEEP;
    end
    assign ch_regs_o[i*DW +: DW] = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      main_ctrl_o <= '0;
      dcdc_ctrl_o <= '0;
    end else if (wr_en_i) begin
      if (wr_code_i == CW'(CODE_MAIN)) main_ctrl_o <= wr_data_i;
      if (wr_code_i == CW'(CODE_DCDC)) dcdc_ctrl_o <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCR; i++)
      if (rd_code_i == CW'(i)) rd_data_o = regs_q[i];
    if (rd_code_i == CW'(CODE_STAT)) rd_data_o = status_i;
    if (rd_code_i == CW'(CODE_MAIN)) rd_data_o = main_ctrl_o;
    if (rd_code_i == CW'(CODE_DCDC)) rd_data_o = dcdc_ctrl_o;
  end
endmodule

// File: rtl/spi_rf_top.sv
module spi_rf_top
  import spi_rf_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DADDR_W-1:0]        dev_addr_i,
  input  logic                      sclk_i,
  input  logic                      cs_n_i,
  input  logic                      mosi_i,
  input  logic [REG_W-1:0]          status_i,
  output logic                      sdo_o,
  output logic                      sdo_oe_o,
  output logic [KINDS*NCH*REG_W-1:0] ch_regs_o,
  output logic [REG_W-1:0]          main_ctrl_o,
  output logic [REG_W-1:0]          dcdc_ctrl_o
);
  logic               frame_valid, cs_fall;
  logic [FRAME_W-1:0] frame_w, pend_q;
  logic [REG_W-1:0]   rd_data;
  logic               rd_req;
  logic [DADDR_W-1:0] f_addr;
  logic [CODE_W-1:0]  f_code;

  assign rd_req = frame_w[RW_POS];
  assign f_addr = frame_w[DADDR_LSB +: DADDR_W];
  assign f_code = frame_w[CODE_LSB +: CODE_W];

  spi_rf_frame #(.FW(FRAME_W), .AW(DADDR_W)) u_frame (
    .clk           (clk),
    .rst           (rst),
    .dev_addr_i    (dev_addr_i),
    .sclk_i        (sclk_i),
    .cs_n_i        (cs_n_i),
    .mosi_i        (mosi_i),
    .load_word_i   (pend_q),
    .sdo_o         (sdo_o),
    .sdo_oe_o      (sdo_oe_o),
    .cs_fall_o     (cs_fall),
    .frame_valid_o (frame_valid),
    .frame_o       (frame_w)
  );

  spi_rf_regs #(.NCH(NCH), .DW(REG_W), .CW(CODE_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en_i     (frame_valid & ~rd_req),
    .wr_code_i   (f_code),
    .wr_data_i   (frame_w[REG_W-1:0]),
    .rd_code_i   (f_code),
    .status_i    (status_i),
    .rd_data_o   (rd_data),
    .ch_regs_o   (ch_regs_o),
    .main_ctrl_o (main_ctrl_o),
    .dcdc_ctrl_o (dcdc_ctrl_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else if (frame_valid) pend_q <= rd_req ? rb_word(f_addr, f_code, rd_data) : '0;
  end
endmodule

// File: rtl/spi_rf_checker.sv
module spi_rf_checker
  import spi_rf_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cs_n_i,
  input logic                       sdo_oe_o,
  input logic                       cs_fall,
  input logic                       frame_valid,
  input logic [KINDS*NCH*REG_W-1:0] ch_regs_o,
  input logic [REG_W-1:0]           main_ctrl_o,
  input logic [REG_W-1:0]           dcdc_ctrl_o
);
  logic [2:0] cyc;
  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  function automatic logic [KINDS*NCH*REG_W-1:0] reset_image();
    logic [KINDS*NCH*REG_W-1:0] v = '0;
    for (int i = KIND_GAIN*NCH; i < (KIND_GAIN+1)*NCH; i++) v[i*REG_W +: REG_W] = '1;
    return v;
  endfunction

  assert_reset_image_R1: assert property (@(posedge clk) disable iff (rst)
    (cyc == 3'd0) |-> (ch_regs_o == reset_image() && main_ctrl_o == '0 && dcdc_ctrl_o == '0));

  assert_oe_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd4 && cs_n_i && $past(cs_n_i) && $past(cs_n_i, 2) && $past(cs_n_i, 3)) |-> !sdo_oe_o);

  assert_oe_start_R10: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd1 && $rose(sdo_oe_o)) |-> $past(cs_fall));

  assert_ch_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd1 && !$stable(ch_regs_o)) |-> $past(frame_valid));

  assert_glob_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (cyc >= 3'd1 && (!$stable(main_ctrl_o) || !$stable(dcdc_ctrl_o))) |-> $past(frame_valid));

  for (genvar c = 0; c < NCH; c++) begin : g_slew
    assert_slew_fields_R3: assert property (@(posedge clk) disable iff (rst)
      (ch_regs_o[(KIND_SLEW*NCH + c)*REG_W +: REG_W] & ~SLEW_KEEP) == '0);
  end
endmodule

bind spi_rf_top spi_rf_checker #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n_i      (cs_n_i),
  .sdo_oe_o    (sdo_oe_o),
  .cs_fall     (cs_fall),
  .frame_valid (frame_valid),
  .ch_regs_o   (ch_regs_o),
  .main_ctrl_o (main_ctrl_o),
  .dcdc_ctrl_o (dcdc_ctrl_o)
);

// File: tb/test_spi_rf_top.sv
`timescale 1ns/1ps
module test_spi_rf_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  dev_addr = 2'b01;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic [15:0] status_v = '0;
  logic        sdo, sdo_oe;
  logic [383:0] ch_regs;
  logic [15:0] main_ctrl, dcdc_ctrl;

  int checks = 0;
  int fails  = 0;
  logic [15:0] mreg [27];
  logic [23:0] pend;

  always #2 clk = ~clk;

  spi_rf_top i_spi_rf_top (
    .clk(clk), .rst(rst), .dev_addr_i(dev_addr), .sclk_i(sclk), .cs_n_i(cs_n),
    .mosi_i(mosi), .status_i(status_v), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .ch_regs_o(ch_regs), .main_ctrl_o(main_ctrl), .dcdc_ctrl_o(dcdc_ctrl)
  );

  task automatic chk(input logic [23:0] act, input logic [23:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mval(input int c);
    if (c < 24) return mreg[c];
    if (c == 24) return status_v;
    if (c == 25 || c == 26) return mreg[c];
    return 16'h0000;
  endfunction

  task automatic check_regs(input string req);
    for (int i = 0; i < 24; i++) chk({8'h0, ch_regs[i*16 +: 16]}, {8'h0, mreg[i]}, req);
    chk({8'h0, main_ctrl}, {8'h0, mreg[25]}, req);
    chk({8'h0, dcdc_ctrl}, {8'h0, mreg[26]}, req);
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got,
                      output logic oe_first, output logic oe_last);
    got = '0; oe_first = 1'b0; oe_last = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      mosi = (k < 24) ? w[23-k] : 1'b0;
      repeat (8) @(negedge clk);
      got = {got[22:0], sdo};
      if (k == 0) oe_first = sdo_oe;
      oe_last = sdo_oe;
      sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic run(input logic [23:0] w, input int nbits, input string req);
    logic [23:0] got;
    logic        oe_f, oe_l;
    logic        match;
    int          c;
    logic [23:0] exp_out;
    match   = (w[22:21] == dev_addr);
    exp_out = pend;
    c       = int'(w[20:16]);
    xfer(w, nbits, got, oe_f, oe_l);
    if (match) begin
      chk({23'h0, oe_f}, 24'h1, "R10");
      if (nbits == 24) chk(got, exp_out, req);
    end else begin
      chk({23'h0, oe_l}, 24'h0, "R8");
    end
    if (match && nbits == 24) begin
      if (w[23]) pend = {1'b0, w[22:21], w[20:16], mval(c)};
      else begin
        if (c < 20) mreg[c] = w[15:0];
        else if (c < 24) mreg[c] = w[15:0] & 16'h107F;
        else if (c == 25 || c == 26) mreg[c] = w[15:0];
        pend = '0;
      end
    end
    check_regs(req);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 27; i++) mreg[i] = (i >= 8 && i < 12) ? 16'hFFFF : 16'h0000;
    pend = '0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check_regs("R1");
    chk({23'h0, sdo_oe}, 24'h0, "R1");

    // R7: nothing requested yet, no-op shifts zeros
    run(24'h3CE000, 24, "R7");
    // R4: gain of channel A through device 1
    run(24'hA80000, 24, "R4");
    run(24'h3CE000, 24, "R4");

    // R2 / R3 / R5 / R6: write every code
    for (int c = 0; c < 32; c++)
      run({1'b0, 2'b01, 5'(c), 16'(c * 16'h1357) ^ 16'hA6C9}, 24, "R2");
    run({1'b0, 2'b01, 5'd23, 16'hFFFF}, 24, "R3");
    run({1'b0, 2'b01, 5'd20, 16'hEF80}, 24, "R3");

    // R4 / R11: read every code with filler bits
    status_v = 16'hBEEF;
    for (int c = 0; c < 32; c++)
      run({1'b1, 2'b01, 5'(c), 16'h5A5A}, 24, "R4");
    run(24'h3CE000, 24, "R11");

    // R6: reserved code reads zero
    run({1'b1, 2'b01, 5'd29, 16'hFFFF}, 24, "R6");
    run(24'h3CE000, 24, "R6");

    // R5: status sampled at end of read frame
    status_v = 16'h1234;
    run({1'b1, 2'b01, 5'd24, 16'h0000}, 24, "R5");
    status_v = 16'h9999;
    run(24'h3CE000, 24, "R5");

    // R7: after a write, the next transfer is zeros
    run({1'b1, 2'b01, 5'd0, 16'h0000}, 24, "R7");
    run({1'b0, 2'b01, 5'd0, 16'h1234}, 24, "R7");
    run(24'h3CE000, 24, "R7");

    // R8: foreign address frames are ignored
    run({1'b1, 2'b01, 5'd9, 16'h0000}, 24, "R8");
    run({1'b1, 2'b10, 5'd0, 16'h0000}, 24, "R8");
    run({1'b0, 2'b11, 5'd1, 16'hDEAD}, 24, "R8");
    run({1'b0, 2'b00, 5'd25, 16'hBEEF}, 24, "R8");
    run(24'h3CE000, 24, "R8");

    // R9: wrong edge counts are discarded
    run({1'b1, 2'b01, 5'd3, 16'h0000}, 24, "R9");
    run({1'b0, 2'b01, 5'd1, 16'hCAFE}, 23, "R9");
    run({1'b0, 2'b01, 5'd1, 16'hF00D}, 25, "R9");
    run(24'h3CE000, 24, "R9");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule